// File: doc/BRIEF.md
# Daisy-Chain Interrupt Acknowledge Chain

This block connects a row of interrupt-capable device slots to one interrupt request line into the CPU. Each slot records a request from its device as a pending flag. The CPU's interrupt line is asserted while any slot holds a pending flag. The slots therefore need no separate lines of their own. The CPU identifies the source by polling in hardware through an acknowledge chain.

When the CPU raises its acknowledge, the acknowledge enters slot 0 and passes from slot to slot. The first slot that holds a pending flag keeps the acknowledge and places its own vector on the shared data bus. The CPU uses that vector to pick a handler routine. Priority is fixed by position, so slot 0 is highest. The winning slot drops its pending flag at the end of that acknowledge cycle. If no slot claims the acknowledge, the bus reads an all-ones default vector and the acknowledge leaves the far end of the chain.

Each slot's vector is a parameter. By default the vector of slot i is `VEC_BASE + i*VEC_STRIDE`, which is 0x40 + 4·i.

Top module: `dchain_intack`

## Requirements
- R1: After reset, no slot is pending, `cpu_intr` is 0, `vec_drive` is 0 and `vec_data` reads 0xFF.
- R2: A 1 on `dev_req[i]` at a rising clock edge makes slot i pending from the next cycle, so `cpu_intr` is 1 in that cycle.
- R3: `cpu_intr` is the OR of all pending flags. It returns to 0 in the cycle after the acknowledge that clears the last pending slot.
- R4: During a cycle with `cpu_inta` = 1, the lowest-numbered pending slot claims the acknowledge, and no other slot does.
- R5: A slot that claims the acknowledge blocks it from every later slot, so `chain_ack_out` is 0 whenever a claim occurs.
- R6: In a claimed acknowledge cycle, `vec_drive` is 1 and `vec_data` equals the claiming slot's vector, which is 0x40 + 4·i by default.
- R7: The claiming slot's pending flag clears at the end of the acknowledge cycle. All other pending flags are kept.
- R8: An acknowledge that no slot claims gives `vec_drive` = 0, `vec_data` = 0xFF and `chain_ack_out` = 1.
- R9: A request that arrives in the same cycle as an acknowledge is not served by that acknowledge. It stays pending for the next one, even when it comes from the slot being served.
- R10: When `cpu_inta` is 0, `vec_drive` is 0, `vec_data` reads 0xFF and `chain_ack_out` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dev_req | input | NUM_SLOTS | Device request per slot, sampled on each rising edge |
| cpu_inta | input | 1 | Interrupt acknowledge from the CPU, one cycle per acknowledge |
| cpu_intr | output | 1 | Shared interrupt request to the CPU |
| vec_data | output | VEC_W | Vector on the data bus, 0xFF when nothing drives it |
| vec_drive | output | 1 | A slot is driving its vector this cycle |
| chain_ack_out | output | 1 | Acknowledge that has passed every slot unclaimed |

## Verification
On every cycle, the assertions check four properties. At most one slot claims an acknowledge, and only while the acknowledge is present. A claim always blocks the chain's far end, and an undriven bus reads the default vector. Request capture and grant clearing are also checked per slot, and the interrupt line may fall only right after an acknowledge. Only the bench's scenarios can show the service order. It sweeps every pending pattern over four slots, acknowledges repeatedly, and expects the vectors in order of ascending slot number. It checks that the interrupt line drops after the last one. It also shows that a request arriving during an acknowledge survives to the next acknowledge.

// File: rtl/dchain_pkg.sv
`timescale 1ns/1ps
package dchain_pkg;
  localparam int unsigned VEC_W = 8;
  typedef logic [VEC_W-1:0] vec_t;

  // Value the bus settles to when no slot drives it.
  function automatic vec_t idle_vector();
    return '1;
  endfunction

  // Vector assigned to a slot position.
  function automatic vec_t slot_vector(vec_t base, vec_t stride, int unsigned idx);
    return vec_t'(base + vec_t'(idx) * stride);
  endfunction
endpackage

// File: rtl/dchain_slot.sv
`timescale 1ns/1ps
module dchain_slot
  import dchain_pkg::*;
#(
  parameter vec_t SLOT_VEC = 8'h40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic ack_in,
  output logic ack_out,
  output logic grant,
  output logic pend,
  output vec_t vec_lane
);
  logic pend_q;

  assign pend     = pend_q;
  assign grant    = ack_in & pend_q;
  assign ack_out  = ack_in & ~pend_q;
  assign vec_lane = grant ? SLOT_VEC : '0;

  // A new request wins over the clear, so it survives to the next acknowledge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pend_q <= 1'b0;
    else if (req)   pend_q <= 1'b1;
    else if (grant) pend_q <= 1'b0;
  end
endmodule

// File: rtl/dchain_busmux.sv
`timescale 1ns/1ps
module dchain_busmux
  import dchain_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 4
) (
  input  logic [NUM_SLOTS-1:0]            grants,
  input  logic [NUM_SLOTS-1:0][VEC_W-1:0] lanes,
  output vec_t                            bus,
  output logic                            driven
);
  vec_t wired;

  always_comb begin
    wired = '0;
    for (int i = 0; i < NUM_SLOTS; i++) wired = wired | lanes[i];
  end

  assign driven = |grants;
  assign bus    = driven ? wired : idle_vector();
endmodule

// File: rtl/dchain_reqor.sv
`timescale 1ns/1ps
module dchain_reqor #(
  parameter int unsigned NUM_SLOTS = 4
) (
  input  logic [NUM_SLOTS-1:0] pends,
  output logic                 any_req
);
  assign any_req = |pends;
endmodule

// File: rtl/dchain_intack.sv
`timescale 1ns/1ps
module dchain_intack
  import dchain_pkg::*;
#(
  parameter int unsigned NUM_SLOTS  = 4,
  parameter vec_t        VEC_BASE   = 8'h40,
  parameter vec_t        VEC_STRIDE = 8'h04
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_SLOTS-1:0] dev_req,
  input  logic                 cpu_inta,
  output logic                 cpu_intr,
  output logic [VEC_W-1:0]     vec_data,
  output logic                 vec_drive,
  output logic                 chain_ack_out
);
  logic [NUM_SLOTS:0]              ack_w;
  logic [NUM_SLOTS-1:0]            grant_w;
  logic [NUM_SLOTS-1:0]            pend_w;
  logic [NUM_SLOTS-1:0][VEC_W-1:0] lane_w;

  assign ack_w[0] = cpu_inta;

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    dchain_slot #(
      .SLOT_VEC(slot_vector(VEC_BASE, VEC_STRIDE, g))
    ) u_slot (
      .clk     (clk),
      .rst_n   (rst_n),
      .req     (dev_req[g]),
      .ack_in  (ack_w[g]),
      .ack_out (ack_w[g+1]),
      .grant   (grant_w[g]),
      .pend    (pend_w[g]),
      .vec_lane(lane_w[g])
    );
  end

  dchain_busmux #(.NUM_SLOTS(NUM_SLOTS)) u_bus (
    .grants(grant_w),
    .lanes (lane_w),
    .bus   (vec_data),
    .driven(vec_drive)
  );

  dchain_reqor #(.NUM_SLOTS(NUM_SLOTS)) u_or (
    .pends  (pend_w),
    .any_req(cpu_intr)
  );

  assign chain_ack_out = ack_w[NUM_SLOTS];
endmodule

// File: rtl/dchain_intack_chk.sv
`timescale 1ns/1ps
module dchain_intack_chk
  import dchain_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NUM_SLOTS-1:0] dev_req,
  input logic                 cpu_inta,
  input logic                 cpu_intr,
  input logic [VEC_W-1:0]     vec_data,
  input logic                 vec_drive,
  input logic                 chain_ack_out,
  input logic [NUM_SLOTS-1:0] pend_w,
  input logic [NUM_SLOTS-1:0] grant_w
);
  AST_SINGLE_CLAIM: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(grant_w)); // R4
  AST_CLAIM_NEEDS_ACK: assert property (@(posedge clk) disable iff (!rst_n) (|grant_w) |-> cpu_inta); // R4
  AST_CLAIM_BLOCKS_CHAIN: assert property (@(posedge clk) disable iff (!rst_n) vec_drive |-> !chain_ack_out); // R5
  AST_IDLE_BUS_DEFAULT: assert property (@(posedge clk) disable iff (!rst_n) !vec_drive |-> (vec_data == idle_vector())); // R8
  AST_NO_ACK_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !cpu_inta |-> (!vec_drive && !chain_ack_out)); // R10
  AST_INTR_FALL_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n) $fell(cpu_intr) |-> $past(cpu_inta)); // R3

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_chk
    AST_REQ_LATCHED: assert property (@(posedge clk) disable iff (!rst_n) dev_req[g] |=> pend_w[g]); // R2
    AST_GRANT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) (grant_w[g] && !dev_req[g]) |=> !pend_w[g]); // R7
  end
endmodule

bind dchain_intack dchain_intack_chk #(.NUM_SLOTS(NUM_SLOTS)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .dev_req      (dev_req),
  .cpu_inta     (cpu_inta),
  .cpu_intr     (cpu_intr),
  .vec_data     (vec_data),
  .vec_drive    (vec_drive),
  .chain_ack_out(chain_ack_out),
  .pend_w       (pend_w),
  .grant_w      (grant_w)
);

// File: tb/dchain_intack_tb.sv
`timescale 1ns/1ps
module dchain_intack_tb;
  localparam int NS = 4;
  localparam int MAX_CYC = 20000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NS-1:0] dev_req = '0;
  logic          cpu_inta = 1'b0;
  logic          cpu_intr;
  logic [7:0]    vec_data;
  logic          vec_drive;
  logic          chain_ack_out;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  dchain_intack u_dut (
    .clk(clk), .rst_n(rst_n), .dev_req(dev_req), .cpu_inta(cpu_inta),
    .cpu_intr(cpu_intr), .vec_data(vec_data), .vec_drive(vec_drive),
    .chain_ack_out(chain_ack_out)
  );

  function automatic logic [7:0] exp_vec(int idx);
    return 8'(8'h40 + idx * 4);
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // Drive at the falling edge, sample 1 ns later, before the next rising edge.
  task automatic pulse_req(input logic [NS-1:0] pat);
    @(negedge clk); dev_req = pat;
    @(negedge clk); dev_req = '0;
  endtask

  task automatic ack_expect(input int idx, input logic [NS-1:0] extra_req);
    @(negedge clk); cpu_inta = 1'b1; dev_req = extra_req;
    #1;
    if (idx >= 0) begin
      check("R6 vec_data", vec_data, exp_vec(idx));
      check("R6 vec_drive", vec_drive, 1);
      check("R5 chain_ack_out", chain_ack_out, 0);
    end else begin
      check("R8 vec_data", vec_data, 8'hFF);
      check("R8 vec_drive", vec_drive, 0);
      check("R8 chain_ack_out", chain_ack_out, 1);
    end
    @(negedge clk); cpu_inta = 1'b0; dev_req = '0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
  endtask

  initial begin
    #(MAX_CYC * 4);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    #3 rst_n = 1'b1;
    @(negedge clk); #1;
    check("R1 cpu_intr", cpu_intr, 0);
    check("R1 vec_drive", vec_drive, 0);
    check("R1 vec_data", vec_data, 8'hFF);
    check("R10 chain_ack_out idle", chain_ack_out, 0);

    // R2 R3 R4 R6 R7: every pending pattern, served in ascending slot order.
    for (int pat = 0; pat < (1 << NS); pat++) begin
      do_reset();
      pulse_req(NS'(pat));
      #1;
      check("R2 cpu_intr after request", cpu_intr, (pat != 0));
      check("R10 idle bus", vec_data, 8'hFF);
      for (int s = 0; s < NS; s++) begin
        if (pat[s]) begin
          ack_expect(s, '0);  // R4 lowest pending slot wins, R7 it then clears
        end
      end
      #1;
      check("R3 cpu_intr after last ack", cpu_intr, 0);
      ack_expect(-1, '0);     // R8 nothing left to claim
    end

    // R9: a request during an acknowledge waits for the next one.
    do_reset();
    pulse_req(4'b0100);
    ack_expect(2, 4'b0001);
    #1;
    check("R9 slot0 still pending", cpu_intr, 1);
    ack_expect(0, '0);
    ack_expect(-1, '0);

    // R9: the served slot requests again in its own acknowledge cycle.
    do_reset();
    pulse_req(4'b0010);
    ack_expect(1, 4'b0010);
    #1;
    check("R9 same slot re-pending", cpu_intr, 1);
    ack_expect(1, '0);
    #1;
    check("R3 cpu_intr cleared", cpu_intr, 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule